// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block sits on a simple word-addressed register bus and sequences one conversion at a time of a multi-channel successive-approximation converter. Software writes a settle count, then writes the control word with the power bit, an input channel and optionally the interrupt enable. The block powers the analog core, waits the programmed number of converter-clock periods, pulses start-of-conversion, and then searches for the result one bit per clock, from the most significant bit down. Each step drives a trial code to the external DAC and samples the comparator.

When the last bit is decided, the result is latched into the data register, the busy flag drops and the interrupt status is set. The interrupt line is the status flag gated by the enable. A single write of zero to the control word powers the core down and clears the pending status. If the power bit is cleared mid-run, the conversion is cancelled and the data register is left as it was. Bus and converter share one clock.

Top module: `sar_ctl`

## Requirements
- R1: After reset, the data, status and control words read 0, the settle word reads DLY_RST (default 8), and `irq` and `adc_pwr` are 0.
- R2: Registers are at word offsets 0x0 data, 0x4 status (bit 0 busy), 0x8 control (bits 2:0 channel, bit 3 power, bit 5 interrupt enable, bit 6 interrupt status) and 0xC settle count (bits 5:0). The settle count reads back the written value masked to 6 bits.
- R3: A control write with bit 3 set while idle starts a conversion, and busy reads 1 in the cycle after the write edge.
- R4: Counting the cycle after the starting write edge as cycle 0, `adc_soc` is high for exactly one cycle, in cycle D, where D is the settle count.
- R5: In the RES cycles after `adc_soc`, `adc_trial` presents trial codes MSB first, starting at 1 << (RES-1). A bit is kept when `adc_cmp` is 1 (input at or above the trial code). The result is the largest code the input is at or above.
- R6: In cycle D+RES+1, busy reads 0, the data register holds the result and control bit 6 reads 1. All three take effect at the same edge.
- R7: `irq` is high exactly when interrupt status and interrupt enable are both set.
- R8: A control write with bit 6 clear clears the interrupt status. Writing zero powers down (`adc_pwr` 0) and drops `irq`.
- R9: A control write with bit 3 set while busy is ignored. The control word, `adc_chan` and the running conversion and its result are unchanged.
- R10: A control write with bit 3 clear while busy aborts the run. Busy reads 0 in the next cycle, the data register keeps its old value, the status stays clear and no `adc_soc` follows.
- R11: A channel number at or above NCH (default 6) still converts. It reads back as written, but `adc_chan` shows 0.
- R12: The data word is right-aligned and unsigned, RES bits wide (default 10), and reads zero above bit RES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Conversion-complete interrupt |
| adc_pwr | output | 1 | Analog core power enable |
| adc_chan | output | 3 | Input multiplexer select |
| adc_soc | output | 1 | One-cycle start-of-conversion pulse |
| adc_trial | output | RES | Trial code to the DAC, 0 outside the search |
| adc_cmp | input | 1 | Comparator: 1 when the input is at or above the trial code |

## Verification
A corrupted settle counter or bit index shows at the ports at once as a shifted `adc_soc` cycle or a wrong first trial code. The completion cycle seen through the busy flag then moves by the same amount. A wrong kept-bit decision first shows as a wrong trial code in the next cycle, and as a wrong data word at completion at most RES cycles later. A lost abort or ignored-write decision shows in the cycle after the write, in the status word or in the control readback and `adc_chan`.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int CH_W  = 3;
    localparam int DLY_W = 6;

    // word index taken from bus_addr[3:2]
    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;
    localparam logic [1:0] OFS_DLY  = 2'd3;

    // control word bit positions
    localparam int CTRL_PWR = 3;
    localparam int CTRL_IEN = 5;
    localparam int CTRL_IST = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_st_e;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int RES     = 10,
    parameter int DLY_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic [RES-1:0]   result_i,
    output logic             start_o,
    output logic             abort_o,
    output logic [DLY_W-1:0] dly_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             pwr_o,
    output logic             ien_o,
    output logic             istat_o
);
    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic             pwr;
        logic             ien;
        logic             istat;
        logic [DLY_W-1:0] dly;
        logic [RES-1:0]   data;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr_ok, wr_ctrl, wr_dly;
    logic  unused_hi;

    assign unused_hi = ^bus_wdata[31:7];

    always_comb begin
        r_d     = r_q;
        wr_ok   = bus_we && (bus_addr[1:0] == 2'b00);
        wr_ctrl = wr_ok && (bus_addr[3:2] == OFS_CTRL);
        wr_dly  = wr_ok && (bus_addr[3:2] == OFS_DLY);
        start_o = wr_ctrl && bus_wdata[CTRL_PWR] && !busy_i;
        abort_o = wr_ctrl && !bus_wdata[CTRL_PWR] && busy_i;

        // a power-on write during a run is dropped as a whole
        if (wr_ctrl && !(busy_i && bus_wdata[CTRL_PWR])) begin
            r_d.chan = bus_wdata[CH_W-1:0];
            r_d.pwr  = bus_wdata[CTRL_PWR];
            r_d.ien  = bus_wdata[CTRL_IEN];
            if (!bus_wdata[CTRL_IST]) begin
                r_d.istat = 1'b0;
            end
        end
        if (wr_dly) begin
            r_d.dly = bus_wdata[DLY_W-1:0];
        end
        if (done_i) begin
            r_d.data  = result_i;
            r_d.istat = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dly <= DLY_W'(DLY_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            case (bus_addr[3:2])
                OFS_DATA: bus_rdata[RES-1:0] = r_q.data;
                OFS_STAT: bus_rdata[0] = busy_i;
                OFS_CTRL: begin
                    bus_rdata[CH_W-1:0] = r_q.chan;
                    bus_rdata[CTRL_PWR] = r_q.pwr;
                    bus_rdata[CTRL_IEN] = r_q.ien;
                    bus_rdata[CTRL_IST] = r_q.istat;
                end
                default:  bus_rdata[DLY_W-1:0] = r_q.dly;
            endcase
        end
    end

    assign dly_o   = r_q.dly;
    assign chan_o  = r_q.chan;
    assign pwr_o   = r_q.pwr;
    assign ien_o   = r_q.ien;
    assign istat_o = r_q.istat;

    // R6: completion always leaves the status flag set
    a_r6_istat_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> r_q.istat);

    // R9: a power-on control write during a run leaves the channel alone
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && busy_i && bus_wdata[CTRL_PWR]) |=> $stable(r_q.chan));

    // R10: the data word only moves on completion
    a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(r_q.data));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             comp_i,
    output logic             busy_o,
    output logic             soc_o,
    output logic             done_o,
    output logic [RES-1:0]   result_o,
    output logic [RES-1:0]   trial_o
);
    localparam int BIT_W = $clog2(RES);

    typedef struct packed {
        seq_st_e          st;
        logic [DLY_W-1:0] cnt;
        logic [BIT_W-1:0] bidx;
        logic [RES-1:0]   code;
    } seq_t;

    seq_t s_q, s_d;

    function automatic logic [RES-1:0] bit_mask(input logic [BIT_W-1:0] i);
        logic [RES-1:0] m;
        m    = '0;
        m[i] = 1'b1;
        return m;
    endfunction

    always_comb begin
        s_d     = s_q;
        soc_o   = 1'b0;
        done_o  = 1'b0;
        trial_o = '0;
        if (s_q.st == ST_CONV) begin
            trial_o = s_q.code | bit_mask(s_q.bidx);
        end
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st   = ST_WAIT;
                    s_d.cnt  = dly_i;
                    s_d.code = '0;
                end
            end
            ST_WAIT: begin
                if (abort_i) begin
                    s_d.st = ST_IDLE;
                end else if (s_q.cnt == '0) begin
                    soc_o    = 1'b1;
                    s_d.st   = ST_CONV;
                    s_d.bidx = BIT_W'(RES - 1);
                    s_d.code = '0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_CONV: begin
                if (abort_i) begin
                    s_d.st = ST_IDLE;
                end else begin
                    if (comp_i) begin
                        s_d.code = trial_o;
                    end
                    if (s_q.bidx == '0) begin
                        done_o = 1'b1;
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.bidx = s_q.bidx - 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = (s_q.st != ST_IDLE);
    assign result_o = s_d.code;

    // R4: the start pulse leads straight into the MSB trial
    a_r4_soc_then_msb: assert property (@(posedge clk) disable iff (!rst_n)
        soc_o |=> (s_q.st == ST_CONV && s_q.bidx == BIT_W'(RES - 1)));

    // R10: an abort leaves the sequencer idle on the next cycle
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_o);

    // R6: completion returns to idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R3: a start from idle makes the block busy
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/sar_ctl.sv
module sar_ctl
    import sar_pkg::*;
#(
    parameter int RES     = 10,
    parameter int NCH     = 6,
    parameter int DLY_RST = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [3:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq,
    output logic            adc_pwr,
    output logic [2:0]      adc_chan,
    output logic            adc_soc,
    output logic [RES-1:0]  adc_trial,
    input  logic            adc_cmp
);
    localparam logic [CH_W-1:0] CH_LIM = CH_W'(NCH);

    logic             busy, done, start, abort;
    logic             pwr, ien, istat;
    logic [RES-1:0]   result;
    logic [DLY_W-1:0] dly;
    logic [CH_W-1:0]  chan;

    sar_regs #(.RES(RES), .DLY_RST(DLY_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy_i   (busy),
        .done_i   (done),
        .result_i (result),
        .start_o  (start),
        .abort_o  (abort),
        .dly_o    (dly),
        .chan_o   (chan),
        .pwr_o    (pwr),
        .ien_o    (ien),
        .istat_o  (istat)
    );

    sar_seq #(.RES(RES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .abort_i (abort),
        .dly_i   (dly),
        .comp_i  (adc_cmp),
        .busy_o  (busy),
        .soc_o   (adc_soc),
        .done_o  (done),
        .result_o(result),
        .trial_o (adc_trial)
    );

    assign adc_chan = (chan < CH_LIM) ? chan : '0;
    assign adc_pwr  = pwr;
    assign irq      = istat & ien;

    // R11: the multiplexer never sees a channel beyond the count
    a_r11_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        adc_chan < CH_LIM);

    // R4: start pulses only while powered
    a_r4_soc_powered: assert property (@(posedge clk) disable iff (!rst_n)
        adc_soc |-> adc_pwr);
endmodule

// File: tb/sim_sar_ctl.sv
module sim_sar_ctl;
    localparam int RES = 10;
    localparam int NCH = 6;
    localparam logic [3:0] A_DATA = 4'h0, A_STAT = 4'h4, A_CTRL = 4'h8, A_DLY = 4'hC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            we = 1'b0;
    logic [3:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq, pwr, soc;
    logic [2:0]      chan;
    logic [RES-1:0]  trial;
    logic [RES-1:0]  stim = '0;
    logic            cmp;

    assign cmp = (stim >= trial);

    int checks = 0;
    int errors = 0;
    logic [31:0] last_data = '0;

    sar_ctl #(.RES(RES), .NCH(NCH), .DLY_RST(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .adc_pwr(pwr),
        .adc_chan(chan), .adc_soc(soc), .adc_trial(trial), .adc_cmp(cmp)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = -1;
        for (int k = 0; k < 60; k++) begin
            rd(A_STAT, v);
            if (!v[0]) begin n = k; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_DATA, v); check("R1 data after reset", v, 0);
        rd(A_STAT, v); check("R1 status after reset", v, 0);
        rd(A_CTRL, v); check("R1 control after reset", v, 0);
        rd(A_DLY, v);  check("R1 settle after reset", v, 8);
        check("R1 irq after reset", irq, 0);
        check("R1 power after reset", pwr, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_DLY, 32'h2A); rd(A_DLY, v); check("R2 settle readback", v, 32'h2A);
        wr(A_DLY, 32'hFF); rd(A_DLY, v); check("R2 settle masked", v, 32'h3F);
        wr(A_CTRL, 32'h25); rd(A_CTRL, v); check("R2 control readback", v, 32'h25);
        rd(A_STAT, v); check("R2 no start without power bit", v, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic run_conv(input logic [2:0] ch, input logic ie,
                            input logic [RES-1:0] code, input int d);
        logic [31:0] v;
        int soc_at, soc_n, done_at;
        logic [RES-1:0] first_trial;
        stim = code;
        wr(A_DLY, 32'(d));
        wr(A_CTRL, {25'd0, 1'b0, ie, 1'b0, 1'b1, ch});
        soc_at = -1; soc_n = 0; done_at = -1; first_trial = '0;
        for (int k = 0; k < 40; k++) begin
            rd(A_STAT, v);
            if (k == 0) begin
                check("R3 busy after start", v, 1);
                check("R11 channel pin", 32'(chan), 32'(ch));
            end
            if (soc) begin soc_n++; if (soc_at < 0) soc_at = k; end
            if (k == d + 1) first_trial = trial;
            if (!v[0] && done_at < 0) done_at = k;
            @(negedge clk);
        end
        check("R4 soc cycle", soc_at, d);
        check("R4 soc width", soc_n, 1);
        check("R5 first trial is MSB", 32'(first_trial), 32'(1) << (RES - 1));
        check("R6 completion cycle", done_at, d + RES + 1);
        rd(A_DATA, v);
        check("R5 R12 result word", v, {22'd0, code});
        last_data = v;
        rd(A_CTRL, v); check("R6 status bit set", 32'(v[6]), 1);
        check("R7 irq follows enable", irq, ie);
        wr(A_CTRL, 32'h0);
        check("R8 irq cleared", irq, 0);
        check("R8 powered down", pwr, 0);
        rd(A_CTRL, v); check("R8 control cleared", v, 0);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        int n;
        stim = 10'h0F0;
        wr(A_DLY, 32'd4);
        wr(A_CTRL, 32'h29);
        wr(A_CTRL, 32'h0A);
        rd(A_CTRL, v); check("R9 control unchanged", v, 32'h29);
        check("R9 channel pin unchanged", 32'(chan), 1);
        wait_idle(n);
        check("R9 run completes", 32'(n >= 0), 1);
        rd(A_DATA, v); check("R9 result of original run", v, 32'h0F0);
        last_data = v;
        check("R9 irq still enabled", irq, 1);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int socs;
        stim = 10'h155;
        wr(A_DLY, 32'd2);
        wr(A_CTRL, 32'h28);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 32'h20);
        rd(A_STAT, v); check("R10 idle after abort", v, 0);
        socs = 0;
        for (int k = 0; k < 30; k++) begin
            if (soc) socs++;
            @(negedge clk);
        end
        check("R10 no soc after abort", socs, 0);
        rd(A_DATA, v); check("R10 data kept", v, last_data);
        rd(A_CTRL, v); check("R10 status clear", 32'(v[6]), 0);
        check("R10 irq low", irq, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_badchan();
        logic [31:0] v;
        int n;
        stim = 10'h2C3;
        wr(A_DLY, 32'd1);
        wr(A_CTRL, 32'h0F);
        check("R11 pin forced to 0", 32'(chan), 0);
        rd(A_CTRL, v); check("R11 readback as written", 32'(v[2:0]), 7);
        wait_idle(n);
        check("R11 run completes", 32'(n >= 0), 1);
        rd(A_DATA, v); check("R11 result", v, 32'h2C3);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        run_conv(3'd2, 1'b1, 10'h1A5, 8);
        run_conv(3'd0, 1'b1, 10'h000, 0);
        run_conv(3'd5, 1'b0, 10'h3FF, 3);
        t_ignore();
        t_abort();
        t_badchan();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule